// File: doc/BRIEF.md
# Protection Region Configuration Register Bank

This block is the software-visible configuration store of a memory protection unit. A word-wide register port (address, write enable, write data, read data) lets firmware program up to sixteen protection regions and a small global control word. Every region's base address and attribute fields are driven out in parallel, so an access checker next to it can compare all regions at once without going through the register port.

Region programming is indirect. A selector register picks the region that the base and attribute registers address. A base write can also carry its own region number, marked by a flag bit. That write retargets itself and moves the selector in the same cycle. Three extra base/attribute pairs mirror the main pair, so a store-multiple of eight words can program four regions back to back.

Top module: `prot_cfg_bank`

## Requirements
- R1: Word 0x00 is read-only. It reads NUM_REGIONS in bits [15:8] and zero in all other bits, and writes to it change nothing.
- R2: Word 0x04 holds the control word. Bit 0 is the global enable, bit 1 keeps checking active in fault and masked handlers, and bit 2 enables the privileged background map. These bits drive `glob_en`, `handler_chk_en` and `priv_bg_en`. Bits [31:3] read zero.
- R3: Word 0x08 holds the region selector in bits [7:0], and bits [31:8] read zero. A write whose bits [7:0] are NUM_REGIONS or more leaves the selector unchanged.
- R4: Word 0x0C is the base register. A write with bit 4 clear stores bits [31:5] into the selected region. A read returns that region's base in [31:5], zero in bit 4 and the selector in [3:0].
- R5: A base write with bit 4 set loads the selector with bits [3:0], zero-extended, and stores bits [31:5] into that region, both on the same clock edge. If bits [3:0] are NUM_REGIONS or more, the whole write is ignored.
- R6: Word 0x10 is the attribute register of the selected region, and a write stores into that region. Its fields are: execute-never at bit 28, permission at [26:24], type extension at [21:19], shareable at 18, cacheable at 17, bufferable at 16, subregion-disable mask at [15:8], size at [5:1] and region enable at bit 0. Bits 31:29, 27, 23:22 and 7:6 read zero.
- R7: The word pairs 0x14/0x18, 0x1C/0x20 and 0x24/0x28 behave exactly like the base/attribute pair at 0x0C/0x10.
- R8: Each region's stored fields appear on the `rgn_*` outputs from the clock edge that writes them. Regions that were not written keep their outputs.
- R9: Reset clears the control word, the selector and every region's base and attributes to zero.
- R10: Word offsets 0x2C to 0x3C read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_addr | input | ADDR_W | Byte address of the register word (bits [1:0] ignored) |
| cfg_we | input | 1 | Write strobe, sampled on the rising edge |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| glob_en | output | 1 | Global protection enable |
| handler_chk_en | output | 1 | Checking kept active in fault and masked handlers |
| priv_bg_en | output | 1 | Privileged background map enable |
| rgn_base | output | NUM_REGIONS x 27 | Base address bits [31:5] of each region |
| rgn_xn | output | NUM_REGIONS | Execute-never per region |
| rgn_perm | output | NUM_REGIONS x 3 | Permission code per region |
| rgn_tex | output | NUM_REGIONS x 3 | Type extension per region |
| rgn_shr | output | NUM_REGIONS | Shareable per region |
| rgn_cch | output | NUM_REGIONS | Cacheable per region |
| rgn_bfr | output | NUM_REGIONS | Bufferable per region |
| rgn_srd | output | NUM_REGIONS x 8 | Subregion disable mask per region |
| rgn_size | output | NUM_REGIONS x 5 | Size code per region |
| rgn_en | output | NUM_REGIONS | Region enable per region |

## Verification
Reads have no latency: `cfg_rdata` follows `cfg_addr` in the same cycle. The bench therefore sets an address just after a falling edge and samples a moment later. Writes take effect on the rising edge that sees `cfg_we`, so both the read-back value and the parallel `rgn_*` outputs are due at the next falling edge. The bench's reference model is updated just after that rising edge, and the full set of region outputs is compared against it at every falling edge. This also catches a write to the wrong region, or a write that should have been dropped, in the very cycle it lands.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;

  typedef enum logic [2:0] {
    K_TYPE, K_CTRL, K_SEL, K_BASE, K_ATTR, K_NONE
  } reg_kind_e;

  typedef struct packed {
    logic       xn;
    logic [2:0] perm;
    logic [2:0] tex;
    logic       shr;
    logic       cch;
    logic       bfr;
    logic [7:0] srd;
    logic [4:0] size;
    logic       en;
  } rgn_attr_t;

  // Word index to register kind; pairs at 3/4, 5/6, 7/8, 9/10.
  function automatic reg_kind_e word_kind(input int unsigned idx);
    if (idx == 0) return K_TYPE;
    if (idx == 1) return K_CTRL;
    if (idx == 2) return K_SEL;
    if (idx >= 3 && idx <= 10) return (idx[0]) ? K_BASE : K_ATTR;
    return K_NONE;
  endfunction

  function automatic rgn_attr_t attr_unpack(input logic [31:0] w);
    rgn_attr_t a;
    a.xn   = w[28];
    a.perm = w[26:24];
    a.tex  = w[21:19];
    a.shr  = w[18];
    a.cch  = w[17];
    a.bfr  = w[16];
    a.srd  = w[15:8];
    a.size = w[5:1];
    a.en   = w[0];
    return a;
  endfunction

  function automatic logic [31:0] attr_pack(input rgn_attr_t a);
    return {3'b0, a.xn, 1'b0, a.perm, 2'b0, a.tex, a.shr, a.cch, a.bfr,
            a.srd, 2'b0, a.size, a.en};
  endfunction

  function automatic logic [31:0] type_word(input int unsigned n);
    logic [7:0] cnt;
    cnt = n[7:0];
    return {16'b0, cnt, 8'b0};
  endfunction

endpackage

// File: rtl/prot_reg_decode.sv
module prot_reg_decode
  import prot_cfg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output reg_kind_e         kind,
  output logic              wr_ctrl,
  output logic              wr_sel,
  output logic              wr_base,
  output logic              wr_attr
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] widx;
  assign widx = addr[ADDR_W-1:2];

  always_comb begin
    kind    = word_kind(32'(widx));
    wr_ctrl = we && (kind == K_CTRL);
    wr_sel  = we && (kind == K_SEL);
    wr_base = we && (kind == K_BASE);
    wr_attr = we && (kind == K_ATTR);
  end
endmodule

// File: rtl/prot_region_slot.sv
module prot_region_slot
  import prot_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_we,
  input  logic        attr_we,
  input  logic [31:0] wdata,
  output logic [26:0] base_q,
  output rgn_attr_t   attr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      attr_q <= '0;
    end else begin
      if (base_we) base_q <= wdata[31:5];
      if (attr_we) attr_q <= attr_unpack(wdata);
    end
  end
endmodule

// File: rtl/prot_cfg_bank.sv
module prot_cfg_bank
  import prot_cfg_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                cfg_addr,
  input  logic                             cfg_we,
  input  logic [31:0]                      cfg_wdata,
  output logic [31:0]                      cfg_rdata,
  output logic                             glob_en,
  output logic                             handler_chk_en,
  output logic                             priv_bg_en,
  output logic [NUM_REGIONS-1:0][26:0]     rgn_base,
  output logic [NUM_REGIONS-1:0]           rgn_xn,
  output logic [NUM_REGIONS-1:0][2:0]      rgn_perm,
  output logic [NUM_REGIONS-1:0][2:0]      rgn_tex,
  output logic [NUM_REGIONS-1:0]           rgn_shr,
  output logic [NUM_REGIONS-1:0]           rgn_cch,
  output logic [NUM_REGIONS-1:0]           rgn_bfr,
  output logic [NUM_REGIONS-1:0][7:0]      rgn_srd,
  output logic [NUM_REGIONS-1:0][4:0]      rgn_size,
  output logic [NUM_REGIONS-1:0]           rgn_en
);
  localparam int SEL_W = 8;
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  reg_kind_e  kind;
  logic       wr_ctrl, wr_sel, wr_base, wr_attr;
  logic [2:0] ctrl_q;
  logic [SEL_W-1:0] sel_q;

  // Named internal events
  logic             sel_wr_ok;     // direct selector write accepted
  logic             sel_redirect;  // base write carrying its own region number
  logic             redirect_ok;   // ... with a number in range
  logic             base_commit;   // a base value is stored this edge
  logic             attr_commit;   // an attribute value is stored this edge
  logic [SEL_W-1:0] tgt;           // region receiving this edge's write
  logic [IDX_W-1:0] sel_idx;

  logic [26:0] base_arr [NUM_REGIONS];
  rgn_attr_t   attr_arr [NUM_REGIONS];

  prot_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (cfg_addr),
    .we      (cfg_we),
    .kind    (kind),
    .wr_ctrl (wr_ctrl),
    .wr_sel  (wr_sel),
    .wr_base (wr_base),
    .wr_attr (wr_attr)
  );

  assign sel_wr_ok    = wr_sel && (32'(cfg_wdata[SEL_W-1:0]) < NUM_REGIONS);
  assign sel_redirect = wr_base && cfg_wdata[4];
  assign redirect_ok  = sel_redirect && (32'(cfg_wdata[3:0]) < NUM_REGIONS);
  assign base_commit  = wr_base && (!sel_redirect || redirect_ok);
  assign attr_commit  = wr_attr;
  assign tgt          = redirect_ok ? {4'b0, cfg_wdata[3:0]} : sel_q;
  assign sel_idx      = sel_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= cfg_wdata[2:0];
      if (sel_wr_ok)        sel_q <= cfg_wdata[SEL_W-1:0];
      else if (redirect_ok) sel_q <= {4'b0, cfg_wdata[3:0]};
    end
  end

  assign glob_en        = ctrl_q[0];
  assign handler_chk_en = ctrl_q[1];
  assign priv_bg_en     = ctrl_q[2];

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
    prot_region_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_we (base_commit && (tgt == SEL_W'(i))),
      .attr_we (attr_commit && (tgt == SEL_W'(i))),
      .wdata   (cfg_wdata),
      .base_q  (base_arr[i]),
      .attr_q  (attr_arr[i])
    );
    assign rgn_base[i] = base_arr[i];
    assign rgn_xn[i]   = attr_arr[i].xn;
    assign rgn_perm[i] = attr_arr[i].perm;
    assign rgn_tex[i]  = attr_arr[i].tex;
    assign rgn_shr[i]  = attr_arr[i].shr;
    assign rgn_cch[i]  = attr_arr[i].cch;
    assign rgn_bfr[i]  = attr_arr[i].bfr;
    assign rgn_srd[i]  = attr_arr[i].srd;
    assign rgn_size[i] = attr_arr[i].size;
    assign rgn_en[i]   = attr_arr[i].en;
  end

  always_comb begin
    unique case (kind)
      K_TYPE:  cfg_rdata = type_word(NUM_REGIONS);
      K_CTRL:  cfg_rdata = {29'b0, ctrl_q};
      K_SEL:   cfg_rdata = {24'b0, sel_q};
      K_BASE:  cfg_rdata = {base_arr[sel_idx], 1'b0, sel_q[3:0]};
      K_ATTR:  cfg_rdata = attr_pack(attr_arr[sel_idx]);
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/prot_cfg_bank_chk.sv
module prot_cfg_bank_chk #(
  parameter int NUM_REGIONS = 16,
  parameter int ADDR_W      = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      cfg_addr,
  input logic                   cfg_we,
  input logic [31:0]            cfg_wdata,
  input logic [31:0]            cfg_rdata,
  input logic                   glob_en,
  input logic                   handler_chk_en,
  input logic                   priv_bg_en,
  input logic [NUM_REGIONS-1:0] rgn_en,
  input logic [7:0]             sel_q,
  input logic                   redirect_ok,
  input logic                   attr_commit,
  input logic                   wr_ctrl
);
  localparam logic [31:0] TYPE_VAL = 32'(NUM_REGIONS) << 8;

  assert_type_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[ADDR_W-1:2] == '0) |-> (cfg_rdata == TYPE_VAL));

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable({glob_en, handler_chk_en, priv_bg_en}));

  assert_sel_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_q) < NUM_REGIONS);

  assert_redirect_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_ok |=> (sel_q == {4'b0, $past(cfg_wdata[3:0])}));

  assert_enable_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !attr_commit |=> $stable(rgn_en));

  assert_ctrl_zero_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[ADDR_W-1:2] == 1) |-> (cfg_rdata[31:3] == '0));

  assert_unused_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr[ADDR_W-1:2] > 10)) |=> $stable(sel_q));
endmodule

bind prot_cfg_bank prot_cfg_bank_chk #(
  .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_addr       (cfg_addr),
  .cfg_we         (cfg_we),
  .cfg_wdata      (cfg_wdata),
  .cfg_rdata      (cfg_rdata),
  .glob_en        (glob_en),
  .handler_chk_en (handler_chk_en),
  .priv_bg_en     (priv_bg_en),
  .rgn_en         (rgn_en),
  .sel_q          (sel_q),
  .redirect_ok    (redirect_ok),
  .attr_commit    (attr_commit),
  .wr_ctrl        (wr_ctrl)
);

// File: tb/prot_cfg_bank_test.sv
`timescale 1ns/1ps
module prot_cfg_bank_test;
  localparam int N = 16;
  localparam logic [31:0] BASE_M = 32'hFFFF_FFE0;
  localparam logic [31:0] ATTR_M = 32'h173F_FF3F;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  cfg_addr = '0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        glob_en, handler_chk_en, priv_bg_en;
  logic [N-1:0][26:0] rgn_base;
  logic [N-1:0]       rgn_xn, rgn_shr, rgn_cch, rgn_bfr, rgn_en;
  logic [N-1:0][2:0]  rgn_perm, rgn_tex;
  logic [N-1:0][7:0]  rgn_srd;
  logic [N-1:0][4:0]  rgn_size;

  int n_chk = 0, n_fail = 0;
  bit running = 0;

  logic [31:0] m_base [N];
  logic [31:0] m_attr [N];
  logic [31:0] m_ctrl;
  logic [31:0] m_sel;

  always #10 clk = ~clk;

  prot_cfg_bank #(.NUM_REGIONS(N), .ADDR_W(6)) uut (.*);

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [5:0] a);
    int w = int'(a[5:2]);
    if (w == 0) return 32'(N) << 8;
    if (w == 1) return m_ctrl;
    if (w == 2) return m_sel;
    if (w >= 3 && w <= 10 && (w % 2 == 1)) return m_base[m_sel] | m_sel;
    if (w >= 4 && w <= 10) return m_attr[m_sel];
    return 32'h0;
  endfunction

  task automatic model_write(input logic [5:0] a, input logic [31:0] d);
    int w = int'(a[5:2]);
    if (w == 1) m_ctrl = d & 32'h7;
    else if (w == 2) begin
      if (d[7:0] < N) m_sel = {24'b0, d[7:0]};
    end else if (w >= 3 && w <= 10 && (w % 2 == 1)) begin
      if (d[4]) begin
        if (d[3:0] < N) begin
          m_sel = {28'b0, d[3:0]};
          m_base[m_sel] = d & BASE_M;
        end
      end else m_base[m_sel] = d & BASE_M;
    end else if (w >= 4 && w <= 10) m_attr[m_sel] = d & ATTR_M;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_we = 1; cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we = 0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    cfg_addr = a;
    #1;
    e = model_read(a);
    check(cfg_rdata === e, tag, 64'(cfg_rdata), 64'(e));
  endtask

  // Per-cycle comparison of all parallel outputs against the model (R8, R2)
  always @(negedge clk) begin
    if (running) begin
      check({priv_bg_en, handler_chk_en, glob_en} === m_ctrl[2:0], "R2 ctrl outputs",
            64'({priv_bg_en, handler_chk_en, glob_en}), 64'(m_ctrl[2:0]));
      for (int i = 0; i < N; i++) begin
        logic [50:0] act, exp;
        act = {rgn_base[i], rgn_xn[i], rgn_perm[i], rgn_tex[i], rgn_shr[i],
               rgn_cch[i], rgn_bfr[i], rgn_srd[i], rgn_size[i], rgn_en[i]};
        exp = {m_base[i][31:5], m_attr[i][28], m_attr[i][26:24], m_attr[i][21:19],
               m_attr[i][18], m_attr[i][17], m_attr[i][16], m_attr[i][15:8],
               m_attr[i][5:1], m_attr[i][0]};
        check(act === exp, "R8 region outputs", 64'(act), 64'(exp));
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_ctrl = 0; m_sel = 0;
    for (int i = 0; i < N; i++) begin m_base[i] = 0; m_attr[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    running = 1;

    // R9 reset state
    for (int a = 0; a < 64; a += 4) rd(6'(a), "R9 reset read");

    // R1 type read-only
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, "R1 type");
    // R2 control
    wr(6'h04, 32'hFFFF_FFFD);
    rd(6'h04, "R2 control");
    wr(6'h04, 32'h0000_0002);
    rd(6'h04, "R2 control second");

    // R3 selector and out-of-range ignore
    wr(6'h08, 32'hABCD_0005);
    rd(6'h08, "R3 selector");
    wr(6'h08, 32'h0000_0010);
    rd(6'h08, "R3 out of range 16");
    wr(6'h08, 32'h0000_00C8);
    rd(6'h08, "R3 out of range 200");

    // R4 base write without flag, read back
    wr(6'h0C, 32'h2000_00EF);
    rd(6'h0C, "R4 base readback");
    // R6 attribute write with all bits set
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, "R6 attribute reserved zero");
    wr(6'h10, 32'h1302_C013);
    rd(6'h10, "R6 attribute fields");

    // R5 redirect to region 9
    wr(6'h0C, 32'h4002_0019);
    rd(6'h08, "R5 selector moved");
    rd(6'h0C, "R5 base stored at target");
    wr(6'h10, 32'h0600_0A17);
    rd(6'h10, "R5 attribute follows new selector");
    // R5 redirect to region 15 (top of range)
    wr(6'h0C, 32'hFFFF_FFFF);
    rd(6'h08, "R5 selector max");
    rd(6'h0C, "R5 base max");

    // R7 alias bursts programming every region
    for (int r = 0; r < N; r++) begin
      logic [5:0] pb;
      pb = 6'(12 + 8 * (r % 4));
      wr(pb, (32'h0800_0000 + 32'(r) * 32'h0010_0000) | 32'h10 | 32'(r));
      wr(pb + 6'h4, 32'h0300_0001 | (32'(r) << 1) | (32'(r) << 8));
    end
    for (int r = 0; r < N; r++) begin
      wr(6'h08, 32'(r));
      rd(6'h14, "R7 alias base read");
      rd(6'h28, "R7 alias attribute read");
    end
    wr(6'h1C, 32'h1234_5660);
    rd(6'h0C, "R7 alias write visible at main");

    // R10 unmapped offsets
    wr(6'h2C, 32'hFFFF_FFFF);
    wr(6'h3C, 32'h0000_0013);
    rd(6'h2C, "R10 unmapped read");
    rd(6'h08, "R10 selector unchanged");
    rd(6'h04, "R10 control unchanged");

    // R5 ignored when region number out of range (only possible with N<16): check flag write of region 0
    wr(6'h0C, 32'h0000_0010);
    rd(6'h08, "R5 redirect to region 0");

    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule